// File: doc/BRIEF.md
# Interrupt Acknowledge and Vector Return Unit

This unit sits between a small set of external interrupt sources and two processors. Each source has a configuration word that sets its vector, its priority, its sense (level or edge), a mask bit and the processors it may be sent to. For each processor the unit picks the best eligible source and raises that processor's interrupt line. It answers the processor's acknowledge pulse with a vector one cycle later. After an acknowledge, the winning source stays in service until the processor writes an end-of-interrupt.

If the cause of a raised interrupt is gone by the time the acknowledge arrives, the unit returns a programmable spurious vector instead. This happens when a level source has dropped or when the source has just been masked.

Out of reset the unit is in a legacy pass-through mode. In that mode source 0 drives processor 0's interrupt line straight through, and source 0 takes no part in arbitration. An acknowledge from processor 0 with no arbitrated interrupt raised is left unanswered, because an external legacy controller supplies that vector. When software clears pass-through, source 0 is handled like every other source.

Top module: `irq_ack_ctrl`

## Requirements
- R1: After reset all interrupt outputs and acknowledge-valid outputs are low. Pass-through mode is on. The spurious vector reads 0xFF, every source configuration reads 0x2000 (masked, all other fields zero), and both task priorities read 0.
- R2: Register map. The address uses bits [5:4] as region and [3:0] as index. Region 0 holds the source configuration words. Region 1 holds the spurious vector at index 0 and the mode bit at index 1 (bit 0, 1 = pass-through). Region 2 holds the task priority per processor. Region 3 takes end-of-interrupt writes per processor. A source word is laid out as vector [7:0], priority [11:8], edge sense [12] (1 = edge), mask [13] (1 = masked) and destination [15:14] (bit 14 = processor 0). A written source word reads back unchanged.
- R3: For each processor, the unmasked pending source with the highest priority whose destination bit selects that processor wins. A tie goes to the lowest source index. The processor's interrupt output is high in the cycle after a winner exists.
- R4: A source is delivered to a processor only if its priority is strictly greater than that processor's threshold. The threshold is the task priority, or the in-service priority when that is higher.
- R5: An acknowledge pulse sampled at a clock edge yields the acknowledge-valid output and the vector in the following cycle, for one cycle. The interrupt output is low in that same cycle and is re-evaluated from the remaining sources one cycle later.
- R6: A level source is pending while its sampled input is high. An edge source becomes pending on a rising edge of its input, stays pending after the input falls, and is cleared by an acknowledge that returns its vector.
- R7: An acknowledge that returns a source vector places that source in service on the acknowledging processor. This blocks sources of equal or lower priority. An end-of-interrupt write ends the in-service state.
- R8: When no eligible source exists at acknowledge, the spurious vector is returned and nothing is placed in service. This includes the case of a level source that raised the interrupt and fell before the acknowledge.
- R9: When a source is masked after raising the interrupt and before the acknowledge, the spurious vector is returned.
- R10: In pass-through mode, processor 0's interrupt output is high in the cycle after input 0 is sampled high, whatever source 0's configuration says. Source 0 is then not delivered to either processor through arbitration.
- R11: In pass-through mode, an acknowledge from processor 0 while no arbitrated interrupt is raised on processor 0 gets no response. Acknowledges for other sources are still answered.
- R12: With pass-through off, source 0 is arbitrated and delivered according to its own priority, destination and vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_i | input | NSRC | External interrupt inputs, synchronous to clk |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | 16 | Register read data, combinational |
| int_o | output | 2 | Interrupt request, one per processor |
| iack_i | input | 2 | Acknowledge pulse, one per processor |
| ack_vld_o | output | 2 | Acknowledge response valid, one per processor |
| ack_vec_o | output | 16 | Returned vectors, processor c at bits [8c+7:8c] |

## Verification
The assertions assume that the source inputs are already synchronous to the clock, that every acknowledge is a single-cycle pulse, and that register writes come one at a time. The bench drives every input just after a falling edge and holds the acknowledge and write strobes for exactly one cycle. It lets sources settle for several cycles before it acknowledges, except in the two spurious cases, where it deliberately removes the cause one cycle before the pulse.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;
  localparam int unsigned PRIO_W = 4;
  localparam int unsigned VEC_W  = 8;
  localparam int unsigned NCPU   = 2;

  typedef logic [PRIO_W-1:0] prio_t;
  typedef logic [VEC_W-1:0]  vec_t;

  // packed MSB first: dest, mask, edge sense, priority, vector
  typedef struct packed {
    logic [NCPU-1:0] dest;
    logic            mask;
    logic            edge_sense;
    prio_t           prio;
    vec_t            vec;
  } src_cfg_t;

  localparam int unsigned CFG_W  = $bits(src_cfg_t);
  localparam int unsigned DATA_W = CFG_W;

  typedef enum logic [1:0] {
    RGN_SRC  = 2'd0,
    RGN_GLB  = 2'd1,
    RGN_TASK = 2'd2,
    RGN_EOI  = 2'd3
  } rgn_e;
endpackage

// File: rtl/irq_src_slot.sv
module irq_src_slot
  import irq_ack_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     src_i,
  input  logic     cfg_we_i,
  input  src_cfg_t cfg_wdata_i,
  input  logic     clr_i,
  output src_cfg_t cfg_o,
  output logic     pend_o,
  output logic     samp_o
);
  src_cfg_t cfg_q, cfg_d;
  logic     samp_q, prev_q;
  logic     epend_q, epend_d;
  logic     rise;

  assign rise = samp_q & ~prev_q;

  always_comb begin
    cfg_d = cfg_q;
    if (cfg_we_i) cfg_d = cfg_wdata_i;
  end

  always_comb begin
    epend_d = epend_q;
    if (!cfg_q.edge_sense) epend_d = 1'b0;
    else if (rise)         epend_d = 1'b1;
    else if (clr_i)        epend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '{dest: '0, mask: 1'b1, edge_sense: 1'b0, prio: '0, vec: '0};
      samp_q  <= 1'b0;
      prev_q  <= 1'b0;
      epend_q <= 1'b0;
    end else begin
      cfg_q   <= cfg_d;
      samp_q  <= src_i;
      prev_q  <= samp_q;
      epend_q <= epend_d;
    end
  end

  assign cfg_o  = cfg_q;
  assign samp_o = samp_q;
  assign pend_o = cfg_q.edge_sense ? epend_q : samp_q;

  // R6
  edge_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.edge_sense && !cfg_we_i && clr_i && !rise) |=> !pend_o);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_ack_pkg::*;
#(
  parameter int unsigned NSRC   = 4,
  parameter int unsigned CPU    = 0,
  localparam int unsigned SIDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0]           pend_i,
  input  src_cfg_t [NSRC-1:0]       cfg_i,
  input  prio_t                     thr_i,
  input  logic                      excl0_i,
  output logic                      win_vld_o,
  output logic [SIDX_W-1:0]         win_idx_o,
  output prio_t                     win_prio_o,
  output vec_t                      win_vec_o
);
  logic [NSRC-1:0] elig;

  for (genvar i = 0; i < NSRC; i++) begin : g_elig
    if (i == 0) begin : g_first
      assign elig[i] = pend_i[i] && !cfg_i[i].mask && cfg_i[i].dest[CPU]
                       && (cfg_i[i].prio > thr_i) && !excl0_i;
    end else begin : g_rest
      assign elig[i] = pend_i[i] && !cfg_i[i].mask && cfg_i[i].dest[CPU]
                       && (cfg_i[i].prio > thr_i);
    end
  end

  always_comb begin
    win_vld_o  = 1'b0;
    win_idx_o  = '0;
    win_prio_o = '0;
    win_vec_o  = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (elig[i] && (!win_vld_o || cfg_i[i].prio > win_prio_o)) begin
        win_vld_o  = 1'b1;
        win_idx_o  = SIDX_W'(i);
        win_prio_o = cfg_i[i].prio;
        win_vec_o  = cfg_i[i].vec;
      end
    end
  end
endmodule

// File: rtl/irq_cpu_port.sv
module irq_cpu_port
  import irq_ack_pkg::*;
#(
  parameter int unsigned CPU = 0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  iack_i,
  input  logic  pt_i,
  input  logic  win_vld_i,
  input  prio_t win_prio_i,
  input  vec_t  win_vec_i,
  input  vec_t  spur_i,
  input  logic  task_we_i,
  input  prio_t task_wdata_i,
  input  logic  eoi_i,
  output logic  irq_o,
  output logic  ack_vld_o,
  output vec_t  ack_vec_o,
  output logic  take_o,
  output prio_t thr_o,
  output prio_t task_o
);
  localparam bit PT_GATE = (CPU == 0);

  logic  int_q, int_d;
  logic  avld_q, avld_d;
  vec_t  avec_q, avec_d;
  logic  isv_q, isv_d;
  prio_t isvp_q, isvp_d;
  prio_t task_q, task_d;
  logic  respond;

  assign respond = iack_i && !(PT_GATE && pt_i && !int_q);
  assign take_o  = respond && win_vld_i;
  assign thr_o   = (isv_q && (isvp_q > task_q)) ? isvp_q : task_q;

  always_comb begin
    int_d  = respond ? 1'b0 : win_vld_i;
    avld_d = respond;
    avec_d = avec_q;
    if (respond) avec_d = win_vld_i ? win_vec_i : spur_i;
    isv_d  = isv_q;
    isvp_d = isvp_q;
    if (take_o) begin
      isv_d  = 1'b1;
      isvp_d = win_prio_i;
    end else if (eoi_i) begin
      isv_d  = 1'b0;
    end
    task_d = task_q;
    if (task_we_i) task_d = task_wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_q  <= 1'b0;
      avld_q <= 1'b0;
      avec_q <= '0;
      isv_q  <= 1'b0;
      isvp_q <= '0;
      task_q <= '0;
    end else begin
      int_q  <= int_d;
      avld_q <= avld_d;
      avec_q <= avec_d;
      isv_q  <= isv_d;
      isvp_q <= isvp_d;
      task_q <= task_d;
    end
  end

  assign irq_o     = int_q;
  assign ack_vld_o = avld_q;
  assign ack_vec_o = avec_q;
  assign task_o    = task_q;

  // R5
  ack_follows_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_vld_o |-> $past(iack_i));
  // R5
  int_drop_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iack_i && int_q) |=> !irq_o);
  // R7
  eoi_clears_isv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_i && !take_o) |=> !isv_q);
  // R11
  pt_ack_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (PT_GATE && pt_i && iack_i && !int_q) |=> !ack_vld_o);
endmodule

// File: rtl/irq_ack_ctrl.sv
module irq_ack_ctrl
  import irq_ack_pkg::*;
#(
  parameter int unsigned NSRC     = 4,
  parameter int unsigned ADDR_W   = 6,
  parameter vec_t        SPUR_RST = '1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NSRC-1:0]         src_i,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [DATA_W-1:0]       rd_data,
  output logic [NCPU-1:0]         int_o,
  input  logic [NCPU-1:0]         iack_i,
  output logic [NCPU-1:0]         ack_vld_o,
  output logic [NCPU*VEC_W-1:0]   ack_vec_o
);
  localparam int unsigned IDX_W  = ADDR_W - 2;
  localparam int unsigned SIDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_pipe_q;
  logic       rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_ns = rst_pipe_q[1];

  rgn_e              wr_rgn, rd_rgn;
  logic [IDX_W-1:0]  wr_idx, rd_idx;
  assign wr_rgn = rgn_e'(wr_addr[ADDR_W-1 -: 2]);
  assign rd_rgn = rgn_e'(rd_addr[ADDR_W-1 -: 2]);
  assign wr_idx = wr_addr[IDX_W-1:0];
  assign rd_idx = rd_addr[IDX_W-1:0];

  // global registers
  vec_t spur_q, spur_d;
  logic pt_q, pt_d;

  always_comb begin
    spur_d = spur_q;
    pt_d   = pt_q;
    if (wr_en && wr_rgn == RGN_GLB) begin
      if (wr_idx == IDX_W'(0)) spur_d = wr_data[VEC_W-1:0];
      if (wr_idx == IDX_W'(1)) pt_d   = wr_data[0];
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      spur_q <= SPUR_RST;
      pt_q   <= 1'b1;
    end else begin
      spur_q <= spur_d;
      pt_q   <= pt_d;
    end
  end

  // per-processor winner signals
  logic [NCPU-1:0]    win_vld, take, cpu_irq;
  logic [SIDX_W-1:0]  win_idx  [NCPU];
  prio_t              win_prio [NCPU];
  vec_t               win_vec  [NCPU];
  prio_t              thr      [NCPU];
  prio_t              task_pr  [NCPU];

  // sources
  src_cfg_t [NSRC-1:0] cfg_all;
  logic [NSRC-1:0]     pend, samp;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic [NCPU-1:0] hit;
    for (genvar c = 0; c < NCPU; c++) begin : g_hit
      assign hit[c] = take[c] && (win_idx[c] == SIDX_W'(i));
    end
    irq_src_slot u_slot (
      .clk         (clk),
      .rst_n       (rst_ns),
      .src_i       (src_i[i]),
      .cfg_we_i    (wr_en && wr_rgn == RGN_SRC && wr_idx == IDX_W'(i)),
      .cfg_wdata_i (src_cfg_t'(wr_data)),
      .clr_i       (|hit),
      .cfg_o       (cfg_all[i]),
      .pend_o      (pend[i]),
      .samp_o      (samp[i])
    );
  end

  // processors
  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    irq_arbiter #(.NSRC(NSRC), .CPU(c)) u_arb (
      .pend_i     (pend),
      .cfg_i      (cfg_all),
      .thr_i      (thr[c]),
      .excl0_i    (pt_q),
      .win_vld_o  (win_vld[c]),
      .win_idx_o  (win_idx[c]),
      .win_prio_o (win_prio[c]),
      .win_vec_o  (win_vec[c])
    );
    irq_cpu_port #(.CPU(c)) u_port (
      .clk          (clk),
      .rst_n        (rst_ns),
      .iack_i       (iack_i[c]),
      .pt_i         (pt_q),
      .win_vld_i    (win_vld[c]),
      .win_prio_i   (win_prio[c]),
      .win_vec_i    (win_vec[c]),
      .spur_i       (spur_q),
      .task_we_i    (wr_en && wr_rgn == RGN_TASK && wr_idx == IDX_W'(c)),
      .task_wdata_i (wr_data[PRIO_W-1:0]),
      .eoi_i        (wr_en && wr_rgn == RGN_EOI && wr_idx == IDX_W'(c)),
      .irq_o        (cpu_irq[c]),
      .ack_vld_o    (ack_vld_o[c]),
      .ack_vec_o    (ack_vec_o[c*VEC_W +: VEC_W]),
      .take_o       (take[c]),
      .thr_o        (thr[c]),
      .task_o       (task_pr[c])
    );
    if (c == 0) begin : g_pt
      assign int_o[c] = cpu_irq[c] | (pt_q & samp[0]);
    end else begin : g_norm
      assign int_o[c] = cpu_irq[c];
    end
  end

  // read port
  always_comb begin
    rd_data = '0;
    unique case (rd_rgn)
      RGN_SRC: begin
        for (int i = 0; i < NSRC; i++)
          if (rd_idx == IDX_W'(i)) rd_data = cfg_all[i];
      end
      RGN_GLB: begin
        if (rd_idx == IDX_W'(0)) rd_data = DATA_W'(spur_q);
        if (rd_idx == IDX_W'(1)) rd_data = DATA_W'(pt_q);
      end
      RGN_TASK: begin
        for (int c = 0; c < NCPU; c++)
          if (rd_idx == IDX_W'(c)) rd_data = DATA_W'(task_pr[c]);
      end
      default: rd_data = '0;
    endcase
  end

  // R10
  pt_route_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (pt_q && $past(rst_ns) && $past(src_i[0])) |-> int_o[0]);
  // R10
  pt_no_arb_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (pt_q && take[1]) |-> (win_idx[1] != '0));
endmodule

// File: tb/tb_irq_ack_ctrl.sv
module tb_irq_ack_ctrl;
  import irq_ack_pkg::*;

  localparam int NSRC = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  src_i = '0;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [5:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic [1:0]  int_o;
  logic [1:0]  iack_i = '0;
  logic [1:0]  ack_vld_o;
  logic [15:0] ack_vec_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_ack_ctrl #(.NSRC(NSRC), .ADDR_W(6)) dut (
    .clk(clk), .rst_n(rst_n), .src_i(src_i),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .int_o(int_o), .iack_i(iack_i),
    .ack_vld_o(ack_vld_o), .ack_vec_o(ack_vec_o)
  );

  localparam logic [5:0] A_SPUR = 6'h10;
  localparam logic [5:0] A_CTRL = 6'h11;

  typedef struct packed {
    logic [3:0] src;
    logic       int0;
    logic       int1;
    logic [7:0] vec0;
  } vrow_t;

  // sources 0..2 level to both cpus prio 2,5,5; source 3 cpu1 only prio 7
  localparam vrow_t TBL [6] = '{
    '{src: 4'b0001, int0: 1'b1, int1: 1'b1, vec0: 8'h40},
    '{src: 4'b0110, int0: 1'b1, int1: 1'b1, vec0: 8'h41},
    '{src: 4'b0100, int0: 1'b1, int1: 1'b1, vec0: 8'h42},
    '{src: 4'b1000, int0: 1'b0, int1: 1'b1, vec0: 8'hA5},
    '{src: 4'b1111, int0: 1'b1, int1: 1'b1, vec0: 8'h41},
    '{src: 4'b0000, int0: 1'b0, int1: 1'b0, vec0: 8'hA5}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic ack(input int c);
    iack_i[c] = 1'b1;
    @(negedge clk);
    iack_i[c] = 1'b0;
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    waitn(3);
    rst_n = 1'b1;
    waitn(4);

    // R1 reset state
    chk("R1 int", {30'b0, int_o}, 0);
    chk("R1 ackvld", {30'b0, ack_vld_o}, 0);
    rd(A_SPUR, d);     chk("R1 spurious", d, 16'h00FF);
    rd(A_CTRL, d);     chk("R1 passthrough", d, 16'h0001);
    rd(6'h00, d);      chk("R1 src0 cfg", d, 16'h2000);
    rd(6'h21, d);      chk("R1 task1", d, 16'h0000);

    // table setup: pass-through off
    @(negedge clk);
    wr(A_CTRL, 16'h0000);
    wr(A_SPUR, 16'h00A5);
    wr(6'h00, 16'hC240);
    wr(6'h01, 16'hC541);
    wr(6'h02, 16'hC542);
    wr(6'h03, 16'h8743);
    rd(6'h03, d);      chk("R2 readback src3", d, 16'h8743);
    rd(A_CTRL, d);     chk("R2 mode bit", d, 16'h0000);

    // R3 R5 R7 R8 table walk
    for (int k = 0; k < 6; k++) begin
      src_i = TBL[k].src;
      waitn(4);
      chk("R3 int0", {31'b0, int_o[0]}, {31'b0, TBL[k].int0});
      chk("R3 int1", {31'b0, int_o[1]}, {31'b0, TBL[k].int1});
      ack(0);
      chk("R5 ackvld", {31'b0, ack_vld_o[0]}, 1);
      chk("R3 R8 vec0", {24'b0, ack_vec_o[7:0]}, {24'b0, TBL[k].vec0});
      chk("R5 int0 low after ack", {31'b0, int_o[0]}, 0);
      @(negedge clk);
      chk("R5 ackvld one cycle", {31'b0, ack_vld_o[0]}, 0);
      waitn(2);
      chk("R7 blocked while in service", {31'b0, int_o[0]}, 0);
      wr(6'h30, 16'h0000);
      src_i = '0;
      waitn(3);
    end

    // R7 EOI re-raises a still-active level source
    src_i = 4'b0010;
    waitn(4);
    ack(0);
    chk("R7 vec", {24'b0, ack_vec_o[7:0]}, 32'h41);
    waitn(3);
    chk("R7 held off", {31'b0, int_o[0]}, 0);
    wr(6'h30, 16'h0000);
    waitn(3);
    chk("R7 re-raised after eoi", {31'b0, int_o[0]}, 1);
    ack(0);
    wr(6'h30, 16'h0000);
    src_i = '0;
    waitn(3);

    // R4 task priority threshold
    wr(6'h20, 16'h0005);
    src_i = 4'b0010;
    waitn(4);
    chk("R4 equal prio blocked", {31'b0, int_o[0]}, 0);
    chk("R4 other cpu delivers", {31'b0, int_o[1]}, 1);
    wr(6'h20, 16'h0004);
    waitn(3);
    chk("R4 lower task delivers", {31'b0, int_o[0]}, 1);
    src_i = '0;
    wr(6'h20, 16'h0000);
    waitn(3);

    // R6 edge source
    wr(6'h02, 16'h5352);
    src_i[2] = 1'b1;
    @(negedge clk);
    src_i[2] = 1'b0;
    waitn(4);
    chk("R6 edge held pending", {31'b0, int_o[0]}, 1);
    ack(0);
    chk("R6 edge vec", {24'b0, ack_vec_o[7:0]}, 32'h52);
    wr(6'h30, 16'h0000);
    waitn(3);
    chk("R6 edge cleared by ack", {31'b0, int_o[0]}, 0);

    // R8 level source falls before acknowledge
    src_i = 4'b0010;
    waitn(4);
    src_i = '0;
    @(negedge clk);
    chk("R8 int still high", {31'b0, int_o[0]}, 1);
    ack(0);
    chk("R8 spurious", {24'b0, ack_vec_o[7:0]}, 32'hA5);
    src_i = 4'b0010;
    waitn(4);
    chk("R8 nothing put in service", {31'b0, int_o[0]}, 1);
    ack(0);
    wr(6'h30, 16'h0000);
    src_i = '0;
    waitn(3);

    // R9 mask set before acknowledge
    src_i = 4'b0010;
    waitn(4);
    wr(6'h01, 16'hE541);
    ack(0);
    chk("R9 spurious on mask", {24'b0, ack_vec_o[7:0]}, 32'hA5);
    rd(6'h01, d);      chk("R2 mask readback", d, 16'hE541);
    src_i = '0;
    wr(6'h01, 16'hC541);
    waitn(3);

    // R12 source 0 arbitrated when pass-through is off
    wr(6'h00, 16'h8360);
    src_i = 4'b0001;
    waitn(4);
    chk("R12 int0", {31'b0, int_o[0]}, 0);
    chk("R12 int1", {31'b0, int_o[1]}, 1);
    ack(1);
    chk("R12 vec1", {24'b0, ack_vec_o[15:8]}, 32'h60);
    wr(6'h31, 16'h0000);
    src_i = '0;
    waitn(3);

    // R10 R11 pass-through on
    wr(A_CTRL, 16'h0001);
    src_i = 4'b0001;
    waitn(2);
    chk("R10 direct to cpu0", {31'b0, int_o[0]}, 1);
    waitn(2);
    chk("R10 not arbitrated to cpu1", {31'b0, int_o[1]}, 0);
    ack(0);
    chk("R11 no response", {31'b0, ack_vld_o[0]}, 0);
    src_i = '0;
    waitn(2);
    chk("R10 follows input", {31'b0, int_o[0]}, 0);
    src_i = 4'b0010;
    waitn(4);
    ack(0);
    chk("R11 other source answered", {31'b0, ack_vld_o[0]}, 1);
    chk("R11 other source vec", {24'b0, ack_vec_o[7:0]}, 32'h41);
    wr(6'h30, 16'h0000);
    src_i = '0;
    waitn(2);

    done = 1;
    summary();
    $finish;
  end
endmodule